// File: doc/BRIEF.md
# Layered LDPC Check-Node Lane with Multi-Edge Accumulation

This block is one lane of a z-parallel layered decoder for quasi-cyclic LDPC codes. A decoder places z copies side by side, one per element of the circulant-sized message vector. The lane works on one check node at a time. It reads the running LLR sum of each neighbouring variable node and the check message that the same edge left behind in the previous iteration. It forms the variable-to-check inputs and runs a min-sum check update. It then writes the new check messages to edge storage and writes the updated sums back to LLR storage.

Both storage arrays sit outside the lane and are reached through plain read ports, which return data in the same cycle, and write ports, which commit at the clock edge. In enhanced mode one variable node may be joined to the same check by several parallel edges, which come from overlapping circulants. Such edges must be listed next to each other, and each repeat carries a set overlap flag. The lane keeps a running delta across the run, so that the last write of the run carries every edge's change. With no flags set, it performs the conventional per-edge layered update.

Top module: `ldpc_multiedge_lane`

## Requirements
- R1: After reset, and whenever the lane is idle, `busy`, `done`, `llr_wr_en` and `edge_wr_en` are all low.
- R2: The lane reads LLR sums as 8-bit two's complement and edge messages as 6-bit two's complement. The input of edge e is q_e = LLR[v_e] − old_e, saturated to the range −128..127.
- R3: The new message of edge e has a magnitude equal to the smallest |q_j| among the other edges j ≠ e of the check, clipped to 31. Its sign bit is the XOR of the sign bits of the other edges' q_j, where a negative q has sign bit 1 and zero counts as positive. A sign bit of 1 gives the negated magnitude, so a message is never −32.
- R4: The new message of edge slot e (0-based) is written to edge address `edge_base + e`.
- R5: For an edge whose overlap flag is low, the lane writes sat8(LLR[v_e] − old_e + new_e) to LLR address v_e. Here LLR[v_e] is the value read before any write of this check.
- R6: Bit e of `ovl_flag` (e ≥ 1) marks that edge e targets the same variable as edge e−1. Across such a run, the value written is sat8(LLR[v] + Σ(new − old)) over all edges of the run so far. The final write therefore holds every edge's change.
- R7: If parallel edges to one variable have their flags low, each write overwrites the previous one, and the variable ends at the value from the last edge alone.
- R8: Bit 0 of `ovl_flag` is ignored.
- R9: `deg` takes any value from 2 to 16. Only the `deg` listed edges and their variables are read or written, and no other storage location changes.
- R10: `start` is accepted only when the lane is idle. `busy` is high from the next cycle until `done` has been shown. `done` is a single-cycle pulse 2·deg+1 cycles after the accepting edge, which is one cycle after the last LLR write.
- R11: Each LLR write saturates at +127 and −128.
- R12: A `start` raised while `busy` is high has no effect on the operation in progress or on storage, and it starts no new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing one check node |
| deg | input | DEG_W (5) | Check degree, 2..MAX_DEG |
| var_idx | input | MAX_DEG*VAR_AW (96) | Variable address of each edge slot, slot e in bits [e*VAR_AW +: VAR_AW] |
| ovl_flag | input | MAX_DEG (16) | Per-slot flag: same variable as the previous slot, accumulate |
| edge_base | input | EDGE_AW (8) | Edge storage address of slot 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| llr_rd_addr | output | VAR_AW (6) | LLR storage read address |
| llr_rd_data | input | LLR_W (8) | LLR storage read data, same cycle |
| llr_wr_en | output | 1 | LLR storage write enable |
| llr_wr_addr | output | VAR_AW (6) | LLR storage write address |
| llr_wr_data | output | LLR_W (8) | LLR storage write data |
| edge_rd_addr | output | EDGE_AW (8) | Edge storage read address |
| edge_rd_data | input | MSG_W (6) | Edge storage read data, same cycle |
| edge_wr_en | output | 1 | Edge storage write enable |
| edge_wr_addr | output | EDGE_AW (8) | Edge storage write address |
| edge_wr_data | output | MSG_W (6) | Edge storage write data |

## Verification
The assertions check the handshake on every cycle:

- the lane stays quiet while idle;
- `busy` rises only on an accepted start;
- `done` is a single pulse that directly follows an LLR write;
- the degree at an accepted start is legal;
- each chained write targets the same address as the write just before it;
- an outgoing message never reaches −32.

The arithmetic can only be shown by the bench's scenarios, which compare all of storage after each operation. This covers the min-sum magnitudes and signs, the accumulation across parallel edges against the overwrite case, saturation, and the fact that nothing outside the addressed edges and variables changes.

// File: rtl/ldpc_lane_pkg.sv
package ldpc_lane_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } lane_state_e;

endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
   import ldpc_lane_pkg::*;
#(
   parameter int MAX_DEG = 16,
   parameter int DEG_W   = $clog2(MAX_DEG + 1),
   parameter int CNT_W   = $clog2(MAX_DEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEG_W-1:0] deg,
   output lane_state_e      state,
   output logic [CNT_W-1:0] cnt,
   output logic             accept,
   output logic             busy
);

   logic [DEG_W-1:0] deg_q;
   logic             last_edge;

   assign accept    = start && (state == ST_IDLE);
   assign last_edge = (DEG_W'(cnt) == deg_q - DEG_W'(1));
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         deg_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  deg_q <= deg;
                  cnt   <= '0;
                  state <= ST_READ;
               end
            end
            ST_READ: begin
               if (last_edge) begin
                  cnt   <= '0;
                  state <= ST_WRITE;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_WRITE: begin
               if (last_edge) begin
                  cnt   <= '0;
                  state <= ST_DONE;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R9: a degree is only accepted inside the supported range
   p_deg_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == ST_IDLE) |-> (deg >= 2 && deg <= MAX_DEG));

   // R10 / R12: busy only ever rises on an accepted start
   p_busy_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

// File: rtl/lane_minsum.sv
module lane_minsum #(
   parameter int MSG_W   = 6,
   parameter int LLR_W   = 8,
   parameter int MAX_DEG = 16,
   parameter int CNT_W   = $clog2(MAX_DEG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    upd,
   input  logic [CNT_W-1:0]        upd_idx,
   input  logic signed [LLR_W-1:0] q_in,
   input  logic                    qry_en,
   input  logic [CNT_W-1:0]        qry_idx,
   output logic signed [MSG_W-1:0] msg_out
);

   localparam int MAG_W   = MSG_W - 1;
   localparam int MAG_MAX = (1 << MAG_W) - 1;
   localparam int MSG_MIN = -(1 << (MSG_W - 1));

   logic signed [LLR_W:0]   q_ext;
   logic signed [LLR_W:0]   q_abs;
   logic [MAG_W-1:0]        mag;
   logic [MAG_W-1:0]        min1, min2, m_sel;
   logic [CNT_W-1:0]        min_idx;
   logic                    sgn_all, s_sel;
   logic [MAX_DEG-1:0]      signs;

   assign q_ext = {q_in[LLR_W-1], q_in};
   assign q_abs = (q_ext < 0) ? -q_ext : q_ext;
   assign mag   = (q_abs > MAG_MAX) ? MAG_W'(MAG_MAX) : q_abs[MAG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min1    <= MAG_W'(MAG_MAX);
         min2    <= MAG_W'(MAG_MAX);
         min_idx <= '0;
         sgn_all <= 1'b0;
         signs   <= '0;
      end else if (clear) begin
         min1    <= MAG_W'(MAG_MAX);
         min2    <= MAG_W'(MAG_MAX);
         min_idx <= '0;
         sgn_all <= 1'b0;
         signs   <= '0;
      end else if (upd) begin
         signs[upd_idx] <= q_in[LLR_W-1];
         sgn_all        <= sgn_all ^ q_in[LLR_W-1];
         if (mag < min1) begin
            min2    <= min1;
            min1    <= mag;
            min_idx <= upd_idx;
         end else if (mag < min2) begin
            min2 <= mag;
         end
      end
   end

   assign m_sel   = (qry_idx == min_idx) ? min2 : min1;
   assign s_sel   = sgn_all ^ signs[qry_idx];
   assign msg_out = s_sel ? -$signed({1'b0, m_sel}) : $signed({1'b0, m_sel});

   // R3: magnitudes are clipped, so the most negative code never leaves
   p_msg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      qry_en |-> (msg_out != MSG_W'(MSG_MIN)));

endmodule

// File: rtl/lane_accum.sv
module lane_accum #(
   parameter int MSG_W   = 6,
   parameter int LLR_W   = 8,
   parameter int MAX_DEG = 16,
   parameter int ACC_W   = MSG_W + 1 + $clog2(MAX_DEG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    chain,
   input  logic signed [MSG_W-1:0] old_msg,
   input  logic signed [MSG_W-1:0] new_msg,
   input  logic signed [LLR_W-1:0] llr_in,
   output logic signed [LLR_W-1:0] llr_out
);

   localparam int SUM_W   = ((ACC_W > LLR_W) ? ACC_W : LLR_W) + 1;
   localparam int LLR_MAX = (1 << (LLR_W - 1)) - 1;
   localparam int LLR_MIN = -(1 << (LLR_W - 1));

   logic signed [MSG_W:0]   delta;
   logic signed [ACC_W-1:0] acc, acc_next;
   logic signed [SUM_W-1:0] sum;

   assign delta    = $signed({new_msg[MSG_W-1], new_msg}) - $signed({old_msg[MSG_W-1], old_msg});
   assign acc_next = (chain ? acc : ACC_W'(0)) + ACC_W'(delta);
   assign sum      = SUM_W'(llr_in) + SUM_W'(acc_next);

   always_comb begin
      if (sum > LLR_MAX)      llr_out = LLR_W'(LLR_MAX);
      else if (sum < LLR_MIN) llr_out = LLR_W'(LLR_MIN);
      else                    llr_out = sum[LLR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= acc_next;
   end

endmodule

// File: rtl/ldpc_multiedge_lane.sv
module ldpc_multiedge_lane
   import ldpc_lane_pkg::*;
#(
   parameter int MSG_W   = 6,
   parameter int LLR_W   = 8,
   parameter int MAX_DEG = 16,
   parameter int VAR_AW  = 6,
   parameter int EDGE_AW = 8,
   parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [DEG_W-1:0]          deg,
   input  logic [MAX_DEG*VAR_AW-1:0] var_idx,
   input  logic [MAX_DEG-1:0]        ovl_flag,
   input  logic [EDGE_AW-1:0]        edge_base,
   output logic                      busy,
   output logic                      done,
   output logic [VAR_AW-1:0]         llr_rd_addr,
   input  logic [LLR_W-1:0]          llr_rd_data,
   output logic                      llr_wr_en,
   output logic [VAR_AW-1:0]         llr_wr_addr,
   output logic [LLR_W-1:0]          llr_wr_data,
   output logic [EDGE_AW-1:0]        edge_rd_addr,
   input  logic [MSG_W-1:0]          edge_rd_data,
   output logic                      edge_wr_en,
   output logic [EDGE_AW-1:0]        edge_wr_addr,
   output logic [MSG_W-1:0]          edge_wr_data
);

   localparam int CNT_W   = $clog2(MAX_DEG);
   localparam int LLR_MAX = (1 << (LLR_W - 1)) - 1;
   localparam int LLR_MIN = -(1 << (LLR_W - 1));

   initial begin
      assert (MSG_W >= 2) else $error("MSG_W too small");
      assert (LLR_W >= MSG_W) else $error("LLR_W must cover MSG_W");
      assert (MAX_DEG >= 2) else $error("MAX_DEG below 2");
      assert (DEG_W >= $clog2(MAX_DEG + 1)) else $error("DEG_W too narrow");
   end

   lane_state_e              state;
   logic [CNT_W-1:0]         cnt;
   logic                     accept, rd_phase, wr_phase, chain;
   logic [MAX_DEG*VAR_AW-1:0] vidx_q;
   logic [MAX_DEG-1:0]       flag_q;
   logic [EDGE_AW-1:0]       base_q, edge_addr;
   logic [VAR_AW-1:0]        var_arr [MAX_DEG];
   logic signed [LLR_W-1:0]  l_arr   [MAX_DEG];
   logic signed [MSG_W-1:0]  o_arr   [MAX_DEG];
   logic signed [LLR_W:0]    q_wide;
   logic signed [LLR_W-1:0]  q_sat;
   logic signed [MSG_W-1:0]  msg_new;
   logic signed [LLR_W-1:0]  llr_new;

   lane_ctrl #(.MAX_DEG(MAX_DEG), .DEG_W(DEG_W), .CNT_W(CNT_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .deg    (deg),
      .state  (state),
      .cnt    (cnt),
      .accept (accept),
      .busy   (busy)
   );

   assign rd_phase = (state == ST_READ);
   assign wr_phase = (state == ST_WRITE);
   assign done     = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vidx_q <= '0;
         flag_q <= '0;
         base_q <= '0;
      end else if (accept) begin
         vidx_q <= var_idx;
         flag_q <= ovl_flag;
         base_q <= edge_base;
      end
   end

   for (genvar e = 0; e < MAX_DEG; e++) begin : g_slot
      assign var_arr[e] = vidx_q[e*VAR_AW +: VAR_AW];
   end

   assign edge_addr = base_q + EDGE_AW'(cnt);

   // variable-to-check input with saturation
   assign q_wide = $signed({llr_rd_data[LLR_W-1], llr_rd_data})
                 - $signed({{(LLR_W + 1 - MSG_W){edge_rd_data[MSG_W-1]}}, edge_rd_data});

   always_comb begin
      if (q_wide > LLR_MAX)      q_sat = LLR_W'(LLR_MAX);
      else if (q_wide < LLR_MIN) q_sat = LLR_W'(LLR_MIN);
      else                       q_sat = q_wide[LLR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rd_phase) begin
         l_arr[cnt] <= llr_rd_data;
         o_arr[cnt] <= edge_rd_data;
      end
   end

   lane_minsum #(.MSG_W(MSG_W), .LLR_W(LLR_W), .MAX_DEG(MAX_DEG), .CNT_W(CNT_W)) u_minsum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .upd     (rd_phase),
      .upd_idx (cnt),
      .q_in    (q_sat),
      .qry_en  (wr_phase),
      .qry_idx (cnt),
      .msg_out (msg_new)
   );

   assign chain = wr_phase && flag_q[cnt] && (cnt != '0);

   lane_accum #(.MSG_W(MSG_W), .LLR_W(LLR_W), .MAX_DEG(MAX_DEG)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wr_phase),
      .chain   (chain),
      .old_msg (o_arr[cnt]),
      .new_msg (msg_new),
      .llr_in  (l_arr[cnt]),
      .llr_out (llr_new)
   );

   assign llr_rd_addr  = var_arr[cnt];
   assign edge_rd_addr = edge_addr;
   assign llr_wr_en    = wr_phase;
   assign llr_wr_addr  = var_arr[cnt];
   assign llr_wr_data  = llr_new;
   assign edge_wr_en   = wr_phase;
   assign edge_wr_addr = edge_addr;
   assign edge_wr_data = msg_new;

   // R1: no storage traffic while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!llr_wr_en && !edge_wr_en));

   // R10: done follows the last LLR write
   p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(llr_wr_en));

   // R10: done lasts one cycle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: a chained write lands on the variable written just before it
   p_chain_same_var_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chain |-> ($past(llr_wr_en) && llr_wr_addr == $past(llr_wr_addr)));

endmodule

// File: tb/tb_ldpc_multiedge_lane.sv
module tb_ldpc_multiedge_lane;

   localparam int MSG_W   = 6;
   localparam int LLR_W   = 8;
   localparam int MAX_DEG = 16;
   localparam int VAR_AW  = 6;
   localparam int EDGE_AW = 8;
   localparam int DEG_W   = 5;
   localparam int NVAR    = 1 << VAR_AW;
   localparam int NEDGE   = 1 << EDGE_AW;

   // deg, edge_base, seed, mode (0 distinct, 1 overlap+flags, 2 overlap no flags, 3 flag on slot 0)
   localparam int NCASE = 8;
   localparam int CASE_TBL [NCASE][4] = '{
      '{16,   0,  3, 0},
      '{ 2,  20,  7, 0},
      '{ 9,  40, 11, 1},
      '{16,  60,  5, 1},
      '{ 7,  90,  9, 2},
      '{12, 120,  2, 3},
      '{ 5, 200, 13, 1},
      '{ 3, 240,  4, 0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DEG_W-1:0] deg = '0;
   logic [MAX_DEG*VAR_AW-1:0] var_idx = '0;
   logic [MAX_DEG-1:0] ovl_flag = '0;
   logic [EDGE_AW-1:0] edge_base = '0;
   logic busy, done;
   logic [VAR_AW-1:0] llr_rd_addr, llr_wr_addr;
   logic [LLR_W-1:0] llr_rd_data, llr_wr_data;
   logic llr_wr_en, edge_wr_en;
   logic [EDGE_AW-1:0] edge_rd_addr, edge_wr_addr;
   logic [MSG_W-1:0] edge_rd_data, edge_wr_data;

   logic signed [LLR_W-1:0] llr_mem  [NVAR];
   logic signed [MSG_W-1:0] edge_mem [NEDGE];
   logic signed [LLR_W-1:0] init_llr [NVAR];
   logic signed [MSG_W-1:0] init_edge[NEDGE];
   logic signed [LLR_W-1:0] exp_llr  [NVAR];
   logic signed [MSG_W-1:0] exp_edge [NEDGE];
   logic load_req = 1'b0;

   int cur_var [MAX_DEG];
   int cur_flag[MAX_DEG];
   int checks = 0;
   int failures = 0;

   always #10ns clk = ~clk;

   ldpc_multiedge_lane #(
      .MSG_W(MSG_W), .LLR_W(LLR_W), .MAX_DEG(MAX_DEG),
      .VAR_AW(VAR_AW), .EDGE_AW(EDGE_AW), .DEG_W(DEG_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .deg(deg),
      .var_idx(var_idx), .ovl_flag(ovl_flag), .edge_base(edge_base),
      .busy(busy), .done(done),
      .llr_rd_addr(llr_rd_addr), .llr_rd_data(llr_rd_data),
      .llr_wr_en(llr_wr_en), .llr_wr_addr(llr_wr_addr), .llr_wr_data(llr_wr_data),
      .edge_rd_addr(edge_rd_addr), .edge_rd_data(edge_rd_data),
      .edge_wr_en(edge_wr_en), .edge_wr_addr(edge_wr_addr), .edge_wr_data(edge_wr_data)
   );

   assign llr_rd_data  = llr_mem[llr_rd_addr];
   assign edge_rd_data = edge_mem[edge_rd_addr];

   always @(posedge clk) begin
      if (load_req) begin
         for (int a = 0; a < NVAR; a++)  llr_mem[a]  <= init_llr[a];
         for (int a = 0; a < NEDGE; a++) edge_mem[a] <= init_edge[a];
      end else begin
         if (llr_wr_en)  llr_mem[llr_wr_addr]   <= llr_wr_data;
         if (edge_wr_en) edge_mem[edge_wr_addr] <= edge_wr_data;
      end
   end

   task automatic check_int(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic fill_init(int seed);
      for (int a = 0; a < NVAR; a++)  init_llr[a]  = LLR_W'(((a * 37 + seed * 11) % 256) - 128);
      for (int a = 0; a < NEDGE; a++) init_edge[a] = MSG_W'(((a * 13 + seed * 7) % 63) - 31);
   endtask

   task automatic load_mems();
      @(negedge clk);
      load_req = 1'b1;
      @(negedge clk);
      load_req = 1'b0;
   endtask

   function automatic int clamp(int v, int lo, int hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   // reference built from R2..R8 and R11
   task automatic model(int d, int base);
      int lv[MAX_DEG]; int ov[MAX_DEG]; int mg[MAX_DEG]; int sg[MAX_DEG]; int nv[MAX_DEG];
      int acc;
      for (int a = 0; a < NVAR; a++)  exp_llr[a]  = llr_mem[a];
      for (int a = 0; a < NEDGE; a++) exp_edge[a] = edge_mem[a];
      for (int e = 0; e < d; e++) begin
         int q;
         lv[e] = int'(llr_mem[cur_var[e]]);
         ov[e] = int'(edge_mem[base + e]);
         q = clamp(lv[e] - ov[e], -128, 127);
         mg[e] = clamp((q < 0) ? -q : q, 0, 31);
         sg[e] = (q < 0) ? 1 : 0;
      end
      for (int e = 0; e < d; e++) begin
         int m; int s;
         m = 31; s = 0;
         for (int j = 0; j < d; j++) begin
            if (j != e) begin
               if (mg[j] < m) m = mg[j];
               s = s ^ sg[j];
            end
         end
         nv[e] = (s != 0) ? -m : m;
      end
      acc = 0;
      for (int e = 0; e < d; e++) begin
         if (e > 0 && cur_flag[e] != 0) acc = acc + nv[e] - ov[e];
         else                           acc = nv[e] - ov[e];
         exp_llr[cur_var[e]] = LLR_W'(clamp(lv[e] + acc, -128, 127));
         exp_edge[base + e]  = MSG_W'(nv[e]);
      end
   endtask

   task automatic run_op(int d, int base, bit spurious, string tag);
      logic [MAX_DEG*VAR_AW-1:0] vb;
      logic [MAX_DEG-1:0] fb;
      int k;
      model(d, base);
      vb = '0;
      fb = '0;
      for (int e = 0; e < MAX_DEG; e++) begin
         vb[e*VAR_AW +: VAR_AW] = VAR_AW'(cur_var[e]);
         fb[e] = (cur_flag[e] != 0);
      end
      @(negedge clk);
      var_idx = vb; ovl_flag = fb; edge_base = EDGE_AW'(base); deg = DEG_W'(d);
      start = 1'b1;
      k = 0;
      while (1) begin
         @(negedge clk);
         k++;
         start = spurious && (k == 3);
         if (spurious && k == 3) deg = DEG_W'(2);
         if (done || k > 200) break;
      end
      start = 1'b0;
      if (k > 200) check_int("R10", "watchdog on done", 0, 1);
      check_int("R10", "start-to-done cycles", k, 2 * d + 1);
      @(negedge clk);
      check_int("R10", "done pulse width", int'(done), 0);
      if (spurious) begin
         @(negedge clk);
         check_int("R12", "busy after spurious start", int'(busy), 0);
      end
      for (int a = 0; a < NVAR; a++)
         check_int(tag, $sformatf("llr[%0d]", a), int'(llr_mem[a]), int'(exp_llr[a]));
      for (int a = 0; a < NEDGE; a++)
         check_int(tag, $sformatf("edge[%0d]", a), int'(edge_mem[a]), int'(exp_edge[a]));
   endtask

   initial begin
      #(20ns * 150000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int e = 0; e < MAX_DEG; e++) begin cur_var[e] = 0; cur_flag[e] = 0; end
      fill_init(1);
      repeat (3) @(negedge clk);
      check_int("R1", "busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      load_mems();
      check_int("R1", "busy after reset", int'(busy), 0);
      check_int("R1", "done after reset", int'(done), 0);
      check_int("R1", "llr_wr_en after reset", int'(llr_wr_en), 0);
      check_int("R1", "edge_wr_en after reset", int'(edge_wr_en), 0);

      // table-driven cases
      for (int c = 0; c < NCASE; c++) begin
         int d; int base; int seed; int mode; int gs; string tag;
         d = CASE_TBL[c][0]; base = CASE_TBL[c][1]; seed = CASE_TBL[c][2]; mode = CASE_TBL[c][3];
         gs = 2 + seed % 2;
         for (int e = 0; e < MAX_DEG; e++) begin
            if (mode == 1 || mode == 2) cur_var[e] = (seed + 5 * (e / gs)) % NVAR;
            else                        cur_var[e] = (seed + 3 * e) % NVAR;
            cur_flag[e] = 0;
            if (mode == 1 && e > 0 && cur_var[e] == (seed + 5 * ((e - 1) / gs)) % NVAR) cur_flag[e] = 1;
            if (mode == 3 && e == 0) cur_flag[e] = 1;
         end
         case (mode)
            0: tag = "R2_R3_R4_R5_R9";
            1: tag = "R6";
            2: tag = "R7";
            default: tag = "R8";
         endcase
         fill_init(seed);
         load_mems();
         run_op(d, base, 1'b0, tag);
      end

      // R3 hand case
      for (int e = 0; e < MAX_DEG; e++) begin cur_var[e] = 0; cur_flag[e] = 0; end
      fill_init(21);
      cur_var[0] = 1; cur_var[1] = 2; cur_var[2] = 3;
      init_llr[1] = 10; init_llr[2] = -4; init_llr[3] = 20;
      init_edge[10] = 0; init_edge[11] = 0; init_edge[12] = 0;
      load_mems();
      run_op(3, 10, 1'b0, "R3");
      check_int("R3", "edge slot0", int'(edge_mem[10]), -4);
      check_int("R3", "edge slot1", int'(edge_mem[11]), 10);
      check_int("R3", "edge slot2", int'(edge_mem[12]), -4);
      check_int("R5", "llr var1", int'(llr_mem[1]), 6);
      check_int("R5", "llr var2", int'(llr_mem[2]), 6);
      check_int("R5", "llr var3", int'(llr_mem[3]), 16);

      // R6 hand case: three parallel edges to variable 7
      fill_init(22);
      for (int e = 0; e < 3; e++) cur_var[e] = 7;
      cur_flag[0] = 0; cur_flag[1] = 1; cur_flag[2] = 1;
      init_llr[7] = 0;
      init_edge[30] = 2; init_edge[31] = 3; init_edge[32] = -5;
      load_mems();
      run_op(3, 30, 1'b0, "R6");
      check_int("R6", "accumulated llr var7", int'(llr_mem[7]), -3);
      check_int("R6", "edge slot0", int'(edge_mem[30]), -3);
      check_int("R6", "edge slot1", int'(edge_mem[31]), -2);
      check_int("R6", "edge slot2", int'(edge_mem[32]), 2);

      // R7 same edges without flags: last edge wins
      cur_flag[1] = 0; cur_flag[2] = 0;
      load_mems();
      run_op(3, 30, 1'b0, "R7");
      check_int("R7", "overwritten llr var7", int'(llr_mem[7]), 7);

      // R11 positive and negative saturation
      for (int e = 0; e < MAX_DEG; e++) begin cur_var[e] = 0; cur_flag[e] = 0; end
      fill_init(23);
      cur_var[0] = 20; cur_var[1] = 21;
      init_llr[20] = 120; init_llr[21] = 120;
      init_edge[50] = -31; init_edge[51] = -31;
      load_mems();
      run_op(2, 50, 1'b0, "R11");
      check_int("R11", "llr var20 high", int'(llr_mem[20]), 127);
      check_int("R3", "edge slot0 high", int'(edge_mem[50]), 31);
      cur_var[0] = 22; cur_var[1] = 23;
      init_llr[22] = -120; init_llr[23] = -120;
      init_edge[52] = 31; init_edge[53] = 31;
      load_mems();
      run_op(2, 52, 1'b0, "R11");
      check_int("R11", "llr var22 low", int'(llr_mem[22]), -128);
      check_int("R3", "edge slot0 low", int'(edge_mem[52]), -31);

      // R12 start while busy
      for (int e = 0; e < MAX_DEG; e++) begin cur_var[e] = (40 + 2 * e) % NVAR; cur_flag[e] = 0; end
      fill_init(24);
      load_mems();
      run_op(6, 100, 1'b1, "R12");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule